// File: doc/BRIEF.md
# Write Request Stream Formatter

This block turns one memory write request into a packet on an AXI4-Stream style output. A request is a 128-bit descriptor, the low bits of the Dword address of the first payload byte, a Dword count, and the byte enables of the first and last payload Dwords. The payload comes from a separate source as full-width words with a valid/ready handshake. The output packet always begins with the 16 descriptor bytes. The payload follows them in one of two placements, chosen per request by a mode input.

In Dword-packed placement (`addrAlignMode` = 0), the first payload Dword comes straight after the descriptor. In address-matched placement (`addrAlignMode` = 1), the payload starts in the beat after the descriptor, on the Dword lane given by the low address bits. The Dwords skipped in that beat are padding and are marked valid in `outKeep`. A sideband bus carries the start-of-packet flag, the two Dword byte-enable nibbles and one enable bit per byte lane. A sink can use the byte-lane enables directly as write strobes.

The payload source is consumed only in step with accepted output beats. No word is buffered inside the block.

Top module: `wr_req_stream_fmt`

## Requirements
- R1: The first four Dwords of every packet carry `reqDesc`, with `reqDesc[32*d+31:32*d]` in stream Dword position d. Stream Dword position p is in beat p/NDW, lane p%NDW, and lane l occupies `outData[32*l+31:32*l]`.
- R2: When `outValid` is high and `outReady` is low, the next cycle has `outValid` high and the same `outData`, `outKeep`, `outUser` and `outLast`. Inside a packet, `outValid` is low only while the current beat needs a payload word and `plValid` is low.
- R3: `outKeep` has one bit per Dword lane. It is set on every position from the first descriptor Dword through the last payload Dword, so it is all ones on every beat except the last one. On the last beat its ones are contiguous from lane 0. Lanes with `outKeep` at 0 carry zero data.
- R4: `outLast` is high on the final beat only. The packet has ceil((B + L) / NDW) beats, where B is the payload start position and L is the payload Dword count.
- R5: `outUser` is laid out as bit 0 = start of packet (first beat only), bits 4:1 = `reqFirstBe`, bits 8:5 = `reqLastBe`, and bits from 9 upward = one enable per byte lane (bit 9 + 4*l + k for byte k of lane l). Bits 8:1 are zero on every beat but the first.
- R6: A byte-lane enable is never set on a descriptor Dword, on a padding Dword, or past the end of the payload.
- R7: With `addrAlignMode` = 0, payload Dword i occupies stream position 4 + i.
- R8: With `addrAlignMode` = 1, payload Dword i occupies position P + A + i. Here P is the descriptor length rounded up to a whole beat, and A is `reqDwAddr`. Padding positions between the descriptor and the payload carry zero data.
- R9: For a payload of two or more Dwords, the first payload Dword's enables equal `reqFirstBe`, the last one's equal `reqLastBe`, and every Dword between them has all four enables set.
- R10: A one-Dword payload (`reqDwLen` = 1) takes its enables from `reqFirstBe` alone.
- R11: `reqDwLen` = 0 is a zero-length write. It is sent as one payload Dword position with `outKeep` set and all four of its byte enables cleared.
- R12: `reqReady` is high only when no packet is in progress. A new request is taken only after the beat with `outLast` has been accepted. A payload word is accepted only in the same cycle as an output beat.
- R13: Payload word w supplies payload Dwords w*NDW through w*NDW+NDW-1, in lane order. Exactly ceil(max(L,1)/NDW) words are taken per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and takes the request |
| reqDesc | input | 128 | Request descriptor |
| reqDwAddr | input | log2(DATA_W/32) | Low bits of the first payload Dword address |
| reqDwLen | input | LEN_W | Payload length in Dwords, 0 for zero-length |
| reqFirstBe | input | 4 | Byte enables of the first payload Dword |
| reqLastBe | input | 4 | Byte enables of the last payload Dword |
| addrAlignMode | input | 1 | 0: Dword-packed, 1: address-matched placement |
| plValid | input | 1 | Payload word present |
| plReady | output | 1 | Payload word taken |
| plData | input | DATA_W | Payload word, Dword 0 in lane 0 |
| outData | output | DATA_W | Stream data |
| outKeep | output | DATA_W/32 | Valid Dword lanes |
| outLast | output | 1 | Last beat of packet |
| outValid | output | 1 | Beat present |
| outReady | input | 1 | Sink takes the beat |
| outUser | output | 9+DATA_W/8 | Start flag, byte-enable nibbles, per-byte enables |

## Verification
The hardest case to reach is a stall in address-matched placement on a beat that combines the held tail of one payload word with the head of the next, while the sink is also stalling. On that beat the output depends on both the stored word and the live source word. The stimulus runs every lane offset in address-matched mode and random lengths, with the sink's ready withheld at random and the source's valid withheld at random. This lets both kinds of stall fall on such mixed beats. Directed zero-, one- and two-Dword writes cover the byte-enable special cases.

// File: rtl/wr_fmt_pkg.sv
package wr_fmt_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;  // latch a new request
    logic pop;   // a payload word is taken this cycle
  } ctrlStrobe_t;

  localparam int DESC_DW = 4;  // descriptor length in Dwords

endpackage

// File: rtl/wr_fmt_ctrl.sv
module wr_fmt_ctrl
  import wr_fmt_pkg::*;
#(
  parameter int BEAT_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              needWord,
  input  logic              lastBeat,
  input  logic              plValid,
  input  logic              outReady,
  output logic              reqReady,
  output logic              outValid,
  output logic              plReady,
  output logic [BEAT_W-1:0] beatIdx,
  output ctrlStrobe_t       strobe
);

  typedef enum logic {S_IDLE, S_SEND} fsm_t;

  fsm_t state;
  logic active;
  logic beatDone;

  assign active   = (state == S_SEND);
  assign reqReady = !active;
  assign outValid = active && (!needWord || plValid);
  assign plReady  = active && needWord && outReady;
  assign beatDone = outValid && outReady;

  assign strobe.load = reqValid && !active;
  assign strobe.pop  = plValid && plReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      beatIdx <= '0;
    end else if (strobe.load) begin
      state   <= S_SEND;
      beatIdx <= '0;
    end else if (beatDone) begin
      if (lastBeat) begin
        state   <= S_IDLE;
        beatIdx <= '0;
      end else begin
        beatIdx <= beatIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wr_fmt_datapath.sv
module wr_fmt_datapath
  import wr_fmt_pkg::*;
#(
  parameter  int DATA_W = 128,
  parameter  int LEN_W  = 11,
  localparam int NDW    = DATA_W / 32,
  localparam int LANE_W = $clog2(NDW),
  localparam int BYTES  = DATA_W / 8,
  localparam int POS_W  = LEN_W + 4,
  localparam int BEAT_W = POS_W - LANE_W,
  localparam int USER_W = 9 + BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [127:0]      reqDesc,
  input  logic [LANE_W-1:0] reqDwAddr,
  input  logic [LEN_W-1:0]  reqDwLen,
  input  logic [3:0]        reqFirstBe,
  input  logic [3:0]        reqLastBe,
  input  logic              addrAlignMode,
  input  logic [DATA_W-1:0] plData,
  input  logic [BEAT_W-1:0] beatIdx,
  output logic              needWord,
  output logic              lastBeat,
  output logic [DATA_W-1:0] outData,
  output logic [NDW-1:0]    outKeep,
  output logic [USER_W-1:0] outUser
);

  // First position usable for an address-matched payload
  localparam int PAD_BASE = ((DESC_DW + NDW - 1) / NDW) * NDW;

  logic [127:0]      descR;
  logic [LANE_W-1:0] dwAddrR;
  logic [LEN_W-1:0]  lenR;
  logic [3:0]        firstBeR;
  logic [3:0]        lastBeR;
  logic              modeR;
  logic [DATA_W-1:0] prevWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descR    <= '0;
      dwAddrR  <= '0;
      lenR     <= '0;
      firstBeR <= '0;
      lastBeR  <= '0;
      modeR    <= 1'b0;
    end else if (strobe.load) begin
      descR    <= reqDesc;
      dwAddrR  <= reqDwAddr;
      lenR     <= reqDwLen;
      firstBeR <= reqFirstBe;
      lastBeR  <= reqLastBe;
      modeR    <= addrAlignMode;
    end
  end

  // Tail of the last taken word feeds the low lanes of the next beat
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prevWord <= '0;
    else if (strobe.pop) prevWord <= plData;
  end

  // Packet geometry
  logic [POS_W-1:0]  lenEff;
  logic [POS_W-1:0]  base;
  logic [POS_W-1:0]  totalDw;
  logic [LANE_W-1:0] rOff;
  logic [BEAT_W-1:0] baseBeat;
  logic [BEAT_W-1:0] lastBeatIdx;
  logic [BEAT_W-1:0] wordCnt;
  logic [BEAT_W-1:0] beatRel;
  logic              zeroLen;
  logic              isFirst;

  assign zeroLen     = (lenR == '0);
  assign lenEff      = zeroLen ? POS_W'(1) : POS_W'(lenR);
  assign base        = modeR ? (POS_W'(PAD_BASE) + POS_W'(dwAddrR)) : POS_W'(DESC_DW);
  assign totalDw     = base + lenEff;
  assign rOff        = base[LANE_W-1:0];
  assign baseBeat    = base[POS_W-1:LANE_W];
  assign lastBeatIdx = BEAT_W'((totalDw - POS_W'(1)) >> LANE_W);
  assign wordCnt     = BEAT_W'((lenEff + POS_W'(NDW - 1)) >> LANE_W);
  assign beatRel     = beatIdx - baseBeat;
  assign needWord    = (beatIdx >= baseBeat) && (beatRel < wordCnt);
  assign lastBeat    = (beatIdx == lastBeatIdx);
  assign isFirst     = (beatIdx == '0);

  logic [BYTES-1:0] byteEn;

  for (genvar j = 0; j < NDW; j++) begin : g_lane
    localparam logic [LANE_W-1:0] LJ = LANE_W'(j);

    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  off;
    logic [LANE_W-1:0] srcLane;
    logic              isDesc;
    logic              isKeep;
    logic              isPay;
    logic              fromCur;
    logic [31:0]       payDw;
    logic [31:0]       descDw;
    logic [3:0]        laneBe;

    assign pos     = {beatIdx, LJ};
    assign isDesc  = (pos < POS_W'(DESC_DW));
    assign isKeep  = (pos < totalDw);
    assign isPay   = isKeep && (pos >= base);
    assign off     = pos - base;
    assign srcLane = LJ - rOff;
    assign fromCur = (LJ >= rOff);
    assign payDw   = fromCur ? plData[srcLane*32 +: 32] : prevWord[srcLane*32 +: 32];
    assign descDw  = descR[pos[1:0]*32 +: 32];

    always_comb begin
      if (!isPay || zeroLen)                 laneBe = 4'h0;
      else if (off == '0)                    laneBe = firstBeR;
      else if (off == lenEff - POS_W'(1))    laneBe = lastBeR;
      else                                   laneBe = 4'hF;
    end

    assign outData[j*32 +: 32] = isDesc ? descDw : (isPay ? payDw : 32'h0);
    assign outKeep[j]          = isKeep;
    assign byteEn[j*4 +: 4]    = laneBe;
  end

  assign outUser = {byteEn,
                    isFirst ? lastBeR  : 4'h0,
                    isFirst ? firstBeR : 4'h0,
                    isFirst};

endmodule

// File: rtl/wr_req_stream_fmt.sv
module wr_req_stream_fmt
  import wr_fmt_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LEN_W  = 11
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [127:0]                 reqDesc,
  input  logic [$clog2(DATA_W/32)-1:0] reqDwAddr,
  input  logic [LEN_W-1:0]             reqDwLen,
  input  logic [3:0]                   reqFirstBe,
  input  logic [3:0]                   reqLastBe,
  input  logic                         addrAlignMode,
  input  logic                         plValid,
  output logic                         plReady,
  input  logic [DATA_W-1:0]            plData,
  output logic [DATA_W-1:0]            outData,
  output logic [DATA_W/32-1:0]         outKeep,
  output logic                         outLast,
  output logic                         outValid,
  input  logic                         outReady,
  output logic [9+DATA_W/8-1:0]        outUser
);

  localparam int LANE_W = $clog2(DATA_W / 32);
  localparam int BEAT_W = LEN_W + 4 - LANE_W;

  ctrlStrobe_t       strobe;
  logic [BEAT_W-1:0] beatIdx;
  logic              needWord;
  logic              lastBeat;

  wr_fmt_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .needWord (needWord),
    .lastBeat (lastBeat),
    .plValid  (plValid),
    .outReady (outReady),
    .reqReady (reqReady),
    .outValid (outValid),
    .plReady  (plReady),
    .beatIdx  (beatIdx),
    .strobe   (strobe)
  );

  wr_fmt_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqDesc       (reqDesc),
    .reqDwAddr     (reqDwAddr),
    .reqDwLen      (reqDwLen),
    .reqFirstBe    (reqFirstBe),
    .reqLastBe     (reqLastBe),
    .addrAlignMode (addrAlignMode),
    .plData        (plData),
    .beatIdx       (beatIdx),
    .needWord      (needWord),
    .lastBeat      (lastBeat),
    .outData       (outData),
    .outKeep       (outKeep),
    .outUser       (outUser)
  );

  assign outLast = lastBeat;

endmodule

// File: rtl/wr_fmt_checker.sv
module wr_fmt_checker #(
  parameter  int DATA_W = 128,
  localparam int NDW    = DATA_W / 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int USER_W = 9 + BYTES,
  localparam int DB     = (BYTES < 16) ? BYTES : 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              plValid,
  input logic              plReady,
  input logic              outValid,
  input logic              outReady,
  input logic              outLast,
  input logic [NDW-1:0]    outKeep,
  input logic [DATA_W-1:0] outData,
  input logic [USER_W-1:0] outUser
);

  logic inPkt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              inPkt <= 1'b0;
    else if (outValid && outReady && outLast) inPkt <= 1'b0;
    else if (outValid && outReady)          inPkt <= 1'b1;
  end

  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outKeep)
                              && $stable(outUser) && $stable(outLast));

  a_r3_keep_full: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |-> &outKeep);

  a_r3_keep_contig: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outKeep[0] && ((outKeep & (outKeep + 1'b1)) == '0));

  a_r4_sop_first: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outUser[0] == !inPkt));

  a_r5_nibbles_first: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outUser[0] |-> (outUser[8:1] == 8'h0));

  a_r6_desc_no_be: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outUser[0] |-> (outUser[9 +: DB] == '0));

  a_r12_busy: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !reqReady);

  a_r12_pop_with_beat: assert property (@(posedge clk) disable iff (!rstN)
    plValid && plReady |-> outValid && outReady);

endmodule

bind wr_req_stream_fmt wr_fmt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .plValid  (plValid),
  .plReady  (plReady),
  .outValid (outValid),
  .outReady (outReady),
  .outLast  (outLast),
  .outKeep  (outKeep),
  .outData  (outData),
  .outUser  (outUser)
);

// File: tb/tb_wr_req_stream_fmt.sv
`timescale 1ns/1ps
module tb_wr_req_stream_fmt;

  localparam int DATA_W   = 128;
  localparam int LEN_W    = 11;
  localparam int NDW      = DATA_W / 32;
  localparam int LANE_W   = $clog2(NDW);
  localparam int BYTES    = DATA_W / 8;
  localparam int USER_W   = 9 + BYTES;
  localparam int PAD_BASE = ((4 + NDW - 1) / NDW) * NDW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [127:0]      reqDesc = '0;
  logic [LANE_W-1:0] reqDwAddr = '0;
  logic [LEN_W-1:0]  reqDwLen = '0;
  logic [3:0]        reqFirstBe = '0;
  logic [3:0]        reqLastBe = '0;
  logic              addrAlignMode = 1'b0;
  logic              plValid = 1'b0;
  logic              plReady;
  logic [DATA_W-1:0] plData = '0;
  logic [DATA_W-1:0] outData;
  logic [NDW-1:0]    outKeep;
  logic              outLast;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [USER_W-1:0] outUser;

  wr_req_stream_fmt #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqDesc(reqDesc), .reqDwAddr(reqDwAddr), .reqDwLen(reqDwLen),
    .reqFirstBe(reqFirstBe), .reqLastBe(reqLastBe), .addrAlignMode(addrAlignMode),
    .plValid(plValid), .plReady(plReady), .plData(plData),
    .outData(outData), .outKeep(outKeep), .outLast(outLast),
    .outValid(outValid), .outReady(outReady), .outUser(outUser)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [255:0] got,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Reference state for the packet in flight
  logic [127:0] curDesc;
  logic [31:0]  payDw [128];
  int           curBase, curLenEff, curLenRaw;
  logic [3:0]   curFbe, curLbe;

  function automatic logic [31:0] expDw(int s);
    if (s < 4) return curDesc[s*32 +: 32];
    if (s >= curBase && s < curBase + curLenEff) return payDw[s - curBase];
    return 32'h0;
  endfunction

  function automatic logic [3:0] expBe(int s);
    if (s < curBase || s >= curBase + curLenEff || curLenRaw == 0) return 4'h0;
    if (s == curBase) return curFbe;
    if (s == curBase + curLenEff - 1) return curLbe;
    return 4'hF;
  endfunction

  function automatic logic [DATA_W-1:0] packWord(int w);
    logic [DATA_W-1:0] v;
    for (int l = 0; l < NDW; l++) v[l*32 +: 32] = payDw[(w*NDW + l) % 128];
    return v;
  endfunction

  task automatic runPacket(input bit mode, input int dwAddr, input int len,
                           input logic [3:0] fbe, input logic [3:0] lbe, input bit steady);
    int nBeats, baseBeat, words, beat, wIdx;
    bit done, popPending, stallPrev, need;
    logic [DATA_W-1:0] sData, eData;
    logic [NDW-1:0]    sKeep, eKeep;
    logic [USER_W-1:0] sUser, eUser;
    logic [BYTES-1:0]  eBe;
    logic              sLast;

    curDesc   = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 128; i++) payDw[i] = $urandom;
    curLenRaw = len;
    curLenEff = (len == 0) ? 1 : len;
    curBase   = mode ? PAD_BASE + dwAddr : 4;
    curFbe    = fbe;
    curLbe    = lbe;
    nBeats    = (curBase + curLenEff + NDW - 1) / NDW;
    baseBeat  = curBase / NDW;
    words     = (curLenEff + NDW - 1) / NDW;

    @(negedge clk);
    reqValid      = 1'b1;
    reqDesc       = curDesc;
    reqDwAddr     = LANE_W'(dwAddr);
    reqDwLen      = LEN_W'(len);
    reqFirstBe    = fbe;
    reqLastBe     = lbe;
    addrAlignMode = mode;
    #1;
    check(reqReady == 1'b1, "R12 idle ready", 256'(reqReady), 256'(1));
    @(negedge clk);
    reqValid = 1'b0;

    beat = 0; wIdx = 0; done = 0; popPending = 0; stallPrev = 0;
    sData = '0; sKeep = '0; sUser = '0; sLast = 1'b0;
    while (!done) begin
      if (popPending) begin plValid = 1'b0; popPending = 0; end
      outReady = steady ? 1'b1 : ($urandom % 4 != 0);
      if (!plValid && wIdx < words && (steady || ($urandom % 3 != 0))) begin
        plValid = 1'b1;
        plData  = packWord(wIdx);
      end
      #1;
      check(reqReady == 1'b0, "R12 busy", 256'(reqReady), 256'(0));
      need = (beat >= baseBeat) && (beat - baseBeat < words);
      check(outValid == !(need && !plValid), "R2 valid continuity",
            256'(outValid), 256'(!(need && !plValid)));
      if (stallPrev) begin
        check(outValid && outData == sData && outKeep == sKeep && outUser == sUser
              && outLast == sLast, "R2 stall hold", 256'(outData), 256'(sData));
      end
      stallPrev = outValid && !outReady;
      sData = outData; sKeep = outKeep; sUser = outUser; sLast = outLast;
      if (plValid && plReady) begin
        check(outValid && outReady, "R12 pop with beat", 256'(outValid && outReady), 256'(1));
        wIdx++;
        popPending = 1;
      end
      if (outValid && outReady) begin
        for (int j = 0; j < NDW; j++) begin
          eData[j*32 +: 32] = expDw(beat*NDW + j);
          eKeep[j]          = (beat*NDW + j) < (curBase + curLenEff);
          eBe[j*4 +: 4]     = expBe(beat*NDW + j);
        end
        eUser = {eBe, (beat == 0) ? lbe : 4'h0, (beat == 0) ? fbe : 4'h0, beat == 0};
        check(outData == eData, "R1/R7/R8/R13 data", 256'(outData), 256'(eData));
        check(outKeep == eKeep, "R3 keep", 256'(outKeep), 256'(eKeep));
        check(outUser == eUser, "R5/R6/R9/R10/R11 user", 256'(outUser), 256'(eUser));
        check(outLast == (beat == nBeats - 1), "R4 last", 256'(outLast),
              256'(beat == nBeats - 1));
        if (beat == nBeats - 1) done = 1;
        beat++;
        if (beat > nBeats) done = 1;
      end
      @(negedge clk);
    end
    plValid  = 1'b0;
    outReady = 1'b0;
    #1;
    check(wIdx == words, "R13 word count", 256'(wIdx), 256'(words));
    check(reqReady == 1'b1, "R12 ready after last", 256'(reqReady), 256'(1));
    check(outValid == 1'b0, "R4 no beat after last", 256'(outValid), 256'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(outValid == 1'b0, "R4 reset no beat", 256'(outValid), 256'(0));
    check(reqReady == 1'b1, "R12 reset ready", 256'(reqReady), 256'(1));
    check(plReady == 1'b0, "R12 reset no pop", 256'(plReady), 256'(0));
    @(negedge clk);
    rstN = 1'b1;

    runPacket(0, 0, 0, 4'h0, 4'h0, 1);            // R11 zero-length, packed
    runPacket(1, 3, 0, 4'h0, 4'h0, 0);            // R11 zero-length, address-matched
    runPacket(0, 0, 1, 4'b0110, 4'h0, 1);         // R10 single Dword
    runPacket(1, 1, 1, 4'b1000, 4'h0, 0);         // R10 single Dword, offset
    runPacket(1, 2, 2, 4'b1000, 4'b0001, 1);      // R9 two Dwords, sparse
    runPacket(0, 0, 2, 4'b0100, 4'b0010, 0);      // R9 two Dwords, packed
    for (int a = 0; a < NDW; a++) runPacket(1, a, 7, 4'b1110, 4'b0011, 1);  // R8 each lane
    runPacket(0, 0, 37, 4'b1100, 4'b0111, 1);     // R7 long, no stalls
    runPacket(1, 3, 50, 4'hF, 4'hF, 0);           // R8 long, stalls

    for (int n = 0; n < 80; n++) begin
      int len;
      logic [3:0] f, l;
      len = ($urandom % 4 == 0) ? int'($urandom % 3) : int'($urandom % 60);
      f   = (len == 0) ? 4'h0 : 4'($urandom % 15 + 1);
      l   = (len <= 1) ? 4'h0 : 4'($urandom % 15 + 1);
      runPacket(1'($urandom % 2), int'($urandom % NDW), len, f, l, ($urandom % 5 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule